// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire station management bus that a MAC uses to reach PHY registers. A host places a 32-bit frame word on `cmdWord` and pulses `start`. The block then runs the whole transaction on its own. It derives the management clock from the system clock and sends a run of ones as preamble. It shifts the 16-bit header out, handles the two-bit turnaround, and then either drives 16 data bits or samples 16 bits returned by the PHY. It closes with a couple of idle clock periods.

The data line is open-drain. The block presents it as an enable (`mdioOe`) plus a value (`mdioOut`), and it reads the resolved line back on `mdioIn`. Bits [31:28] of the command word select the operation: the pattern 0110 means read, and every other pattern means write. When the transaction ends, `done` pulses once and `result` holds the outcome. For a read, `result` is the header joined with the sampled data. For a write, it is the header alone in the low half.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transactions, mdc=1, mdioOe=1, mdioOut=1, busy=0, done=0 and result=0 (result is 0 only until the first transaction completes).
- R2: Each transaction starts with 32 bit times in which MDIO is driven (mdioOe=1) at value 1 at every rising edge of mdc.
- R3: While busy, each mdc half period lasts exactly HALF_DIV system clock cycles, so the MDC period is 2*HALF_DIV cycles. A transaction has exactly 68 rising edges of mdc: 32 preamble, 16 header, 2 turnaround, 16 data and 2 idle.
- R4: mdioOut and mdioOe change only in the system cycle in which mdc falls. PHY and master therefore both see a stable value at the rising edge.
- R5: The operation is a read when cmdWord[31:28] == 4'b0110. Any other value gives a write.
- R6: Bits 33..48 (1-based rising-edge count) carry cmdWord[31:16], driven, most significant bit first.
- R7: During the two turnaround bits and the 16 data bits of a read, mdioOe=0. During the turnaround of a write, the master drives 1 and then 0.
- R8: On a read, MDIO is sampled at rising edges 51..66, MSB first, and result = {cmdWord[31:16], sampled data}.
- R9: On a write, rising edges 51..66 carry cmdWord[15:0], driven, MSB first, and result = {16'h0000, cmdWord[31:16]}.
- R10: The last two bit times drive MDIO high, and the transaction ends with mdc=1, mdioOe=1 and mdioOut=1.
- R11: busy is 1 from the cycle after an accepted start until done. A start pulse while busy has no effect on the frame, the edge count or the result.
- R12: done is high for exactly one cycle per transaction. result changes only in that cycle and holds until the next transaction's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| cmdWord | input | 32 | Management frame word: header in [31:16], write data in [15:0] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Read: header and data; write: header in low half |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value presented on the data line when enabled |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Resolved data line as seen by the master |

## Verification
The bench replays a table of frames through a simple PHY model and records every bit the master drives, sampled at each rising mdc edge. Read frames carry the return data patterns 0xA5C3, 0xFFFF and 0x0000. These show whether capture order, bit alignment and stuck bits are correct, and whether the line is released in the turnaround. Write frames use the opcode nibbles 0101, 0111 and 0010, so a decoder that tests only some bits of 0110 treats one of them as a read and is caught. A start pulse in the middle of a frame, and a long idle wait after done, show whether busy blocking and result holding are in place.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS = 32;
  localparam int HDR_BITS = 16;
  localparam int TA_BITS  = 2;
  localparam int DAT_BITS = 16;
  localparam int CMD_W    = HDR_BITS + DAT_BITS;
  localparam logic [3:0] READ_NIBBLE = 4'b0110;

  typedef enum logic [2:0] {
    SEG_PRE,
    SEG_HDR,
    SEG_TA,
    SEG_DAT,
    SEG_IDLE
  } mdioSeg_e;

  typedef struct packed {
    logic     load;     // accept new command word
    logic     fall;     // mdc falls this cycle: update line
    logic     rise;     // mdc rises this cycle: sample line
    logic     finish;   // last rising edge of the frame
    logic     taFirst;  // current bit is the first turnaround bit
    mdioSeg_e seg;      // frame segment of the current bit
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV  = 10,
  parameter int IDLE_BITS = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output logic      busy,
  output logic      done,
  output logic      mdc,
  output mdioStrb_t strb
);
  localparam int HDR_START = PRE_BITS;
  localparam int TA_START  = HDR_START + HDR_BITS;
  localparam int DAT_START = TA_START + TA_BITS;
  localparam int IDL_START = DAT_START + DAT_BITS;
  localparam int TOTAL     = IDL_START + IDLE_BITS;
  localparam int IDX_W     = $clog2(TOTAL + 1);
  localparam int DIV_W     = $clog2(HALF_DIV + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             tick;

  assign tick = busy && (divCnt == DIV_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mdc    <= 1'b1;
      divCnt <= '0;
      bitIdx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          divCnt <= '0;
          bitIdx <= '0;
        end
      end else if (tick) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (!mdc) begin
          if (bitIdx == LAST_IDX) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load    = !busy && start;
    strb.fall    = tick && mdc;
    strb.rise    = tick && !mdc;
    strb.finish  = tick && !mdc && (bitIdx == LAST_IDX);
    strb.taFirst = (bitIdx == IDX_W'(TA_START));
    if (bitIdx < IDX_W'(HDR_START))      strb.seg = SEG_PRE;
    else if (bitIdx < IDX_W'(TA_START))  strb.seg = SEG_HDR;
    else if (bitIdx < IDX_W'(DAT_START)) strb.seg = SEG_TA;
    else if (bitIdx < IDX_W'(IDL_START)) strb.seg = SEG_DAT;
    else                                 strb.seg = SEG_IDLE;
  end

  // Independent half-period measurement for the clock-rate check.
  logic [DIV_W-1:0] sinceEdge;
  logic             mdcQ;
  always_ff @(posedge clk) begin
    if (rst) begin
      sinceEdge <= '0;
      mdcQ      <= 1'b1;
    end else begin
      mdcQ <= mdc;
      if (!busy)            sinceEdge <= '0;
      else if (mdc != mdcQ) sinceEdge <= DIV_W'(1);
      else                  sinceEdge <= sinceEdge + 1'b1;
    end
  end

  p_mdc_half_r3: assert property (@(posedge clk) disable iff (rst)
    (mdc != $past(mdc)) |-> ($past(sinceEdge) == DIV_TOP));

  p_idle_clock_high_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> mdc);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_clear_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  mdioStrb_t        strb,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic [CMD_W-1:0] result
);
  logic [CMD_W-1:0]    txReg;
  logic [DAT_BITS-1:0] rxReg;
  logic [HDR_BITS-1:0] hdrReg;
  logic                isRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      txReg   <= '0;
      rxReg   <= '0;
      hdrReg  <= '0;
      isRead  <= 1'b0;
      mdioOe  <= 1'b1;
      mdioOut <= 1'b1;
      result  <= '0;
    end else begin
      if (strb.load) begin
        txReg  <= cmdWord;
        hdrReg <= cmdWord[CMD_W-1 -: HDR_BITS];
        isRead <= (cmdWord[CMD_W-1 -: 4] == READ_NIBBLE);
      end
      if (strb.fall) begin
        unique case (strb.seg)
          SEG_HDR: begin
            mdioOe  <= 1'b1;
            mdioOut <= txReg[CMD_W-1];
            txReg   <= txReg << 1;
          end
          SEG_TA: begin
            mdioOe  <= !isRead;
            mdioOut <= isRead ? 1'b1 : strb.taFirst;
          end
          SEG_DAT: begin
            mdioOe  <= !isRead;
            mdioOut <= isRead ? 1'b1 : txReg[CMD_W-1];
            if (!isRead) txReg <= txReg << 1;
          end
          default: begin
            mdioOe  <= 1'b1;
            mdioOut <= 1'b1;
          end
        endcase
      end
      if (strb.rise && isRead && (strb.seg == SEG_DAT))
        rxReg <= {rxReg[DAT_BITS-2:0], mdioIn};
      if (strb.finish)
        result <= isRead ? {hdrReg, rxReg} : {{DAT_BITS{1'b0}}, hdrReg};
    end
  end

  p_line_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    ((mdioOut != $past(mdioOut)) || (mdioOe != $past(mdioOe))) |-> $past(strb.fall));

  p_result_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.finish) |-> (result == $past(result)));

  p_release_read_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.rise && isRead && (strb.seg == SEG_DAT)) |-> !mdioOe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV  = 10,
  parameter int IDLE_BITS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] cmdWord,
  output logic        busy,
  output logic        done,
  output logic [31:0] result,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrb_t strb;

  mdio_ctrl #(.HALF_DIV(HALF_DIV), .IDLE_BITS(IDLE_BITS)) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .mdc   (mdc),
    .strb  (strb)
  );

  mdio_dp uDp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .cmdWord (cmdWord),
    .mdioIn  (mdioIn),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe),
    .result  (result)
  );
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HALF = 10;
  localparam int NBITS = 68;
  localparam int NVEC = 7;
  // {command word, data returned by the PHY model}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h6086_0000, 16'hA5C3},
    {32'h61FE_0000, 16'hFFFF},
    {32'h6002_0000, 16'h0000},
    {32'h5082_1234, 16'h0000},
    {32'h50FE_FFFF, 16'hFFFF},
    {32'h7082_8001, 16'h5A5A},
    {32'h2A55_0F0F, 16'h1111}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] cmdWord = '0;
  logic busy, done, mdc, mdioOut, mdioOe, mdioIn;
  logic [31:0] result;

  logic phyOe = 1'b0, phyVal = 1'b1;
  logic curRead = 1'b0;
  logic [15:0] phyData = '0;
  int fallCnt = 0, riseCnt = 0;
  logic capOe [80];
  logic capOut [80];
  int checks = 0, errors = 0;

  assign mdioIn = mdioOe ? mdioOut : (phyOe ? phyVal : 1'b1);

  mdio_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .start(start), .cmdWord(cmdWord),
    .busy(busy), .done(done), .result(result),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;

  // PHY model: puts read data on the line after each falling edge.
  initial forever begin
    @(negedge mdc);
    if (curRead && fallCnt >= 50 && fallCnt < 66) begin
      phyOe  = 1'b1;
      phyVal = phyData[15 - (fallCnt - 50)];
    end else begin
      phyOe = 1'b0;
    end
    fallCnt++;
  end

  // Record what the master presents at each rising edge.
  initial forever begin
    @(posedge mdc);
    if (riseCnt < 80) begin
      capOe[riseCnt]  = mdioOe;
      capOut[riseCnt] = mdioOut;
    end
    riseCnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finishRun();
  end

  // Run one frame; optionally pulse start again in the middle of it.
  task automatic runTxn(input logic [31:0] c, input logic [15:0] pd, input bit midStart);
    bit rd;
    int doneWidth;
    int waitCnt;
    bit ok;
    logic [31:0] expRes;
    rd = (c[31:28] == 4'b0110);  // R5
    curRead = rd;
    phyData = pd;
    fallCnt = 0;
    riseCnt = 0;
    @(negedge clk);
    cmdWord = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", {31'b0, busy}, 32'h1);
    waitCnt = 0;
    while (!done && waitCnt < 5000) begin
      if (midStart && waitCnt == 300) begin
        cmdWord = ~c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmdWord = c;
        waitCnt++;
      end else begin
        @(negedge clk);
        waitCnt++;
      end
    end
    check(done == 1'b1, "R12 done seen", {31'b0, done}, 32'h1);
    doneWidth = 0;
    while (done && doneWidth < 10) begin
      doneWidth++;
      @(negedge clk);
    end
    check(doneWidth == 1, "R12 done width", doneWidth, 1);
    check(riseCnt == NBITS, "R3 rising edge count", riseCnt, NBITS);
    ok = 1;
    for (int b = 0; b < 32; b++) if (!(capOe[b] && capOut[b])) ok = 0;
    check(ok, "R2 preamble", 0, 0);
    ok = 1;
    for (int b = 0; b < 16; b++) if (!(capOe[32+b] && capOut[32+b] == c[31-b])) ok = 0;
    check(ok, "R6 header bits", c, c);
    if (rd) begin
      ok = 1;
      for (int b = 48; b < 66; b++) if (capOe[b]) ok = 0;
      check(ok, "R7 read release", 0, 0);
      expRes = {c[31:16], pd};  // R8
      check(result == expRes, "R8 read result", result, expRes);
    end else begin
      ok = capOe[48] && capOut[48] && capOe[49] && !capOut[49];
      check(ok, "R7 write turnaround", {capOut[48], capOut[49]}, 32'h2);
      ok = 1;
      for (int b = 0; b < 16; b++) if (!(capOe[50+b] && capOut[50+b] == c[15-b])) ok = 0;
      check(ok, "R9 write data bits", c, c);
      expRes = {16'h0000, c[31:16]};
      check(result == expRes, "R9 write result", result, expRes);
    end
    ok = capOe[66] && capOut[66] && capOe[67] && capOut[67];
    check(ok, "R10 idle bits", 0, 0);
    check(mdc && mdioOe && mdioOut && !busy, "R10 end line state",
          {mdc, mdioOe, mdioOut, busy}, 32'he);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mdc && mdioOe && mdioOut && !busy && !done, "R1 reset line state",
          {mdc, mdioOe, mdioOut, busy, done}, 32'h1c);
    check(result == 32'h0, "R1 reset result", result, 0);
    for (int i = 0; i < NVEC; i++) runTxn(VEC[i][47:16], VEC[i][15:0], 1'b0);
    // R11: start pulse in mid-frame with a different command is ignored
    runTxn(32'h6123_0000, 16'hC0DE, 1'b1);
    // R12: result holds while idle
    repeat (200) @(negedge clk);
    check(result == 32'h6123_C0DE, "R12 result held", result, 32'h6123_C0DE);
    check(mdc && mdioOe && mdioOut, "R1 idle line", {mdc, mdioOe, mdioOut}, 32'h7);
    finishRun();
  end
endmodule